// File: doc/BRIEF.md
# Buffered Block-Program Command Engine for a Byte-Addressed Flash Array

This block is the command sequencer of a NOR-style flash device that can program a whole block of words in a single operation. A host issues bus writes. In the idle state the low byte of a write is a command. A start command is followed by a word count, then by that many data writes, then by a confirm byte. The data writes go to a shadow buffer that holds exactly one write block. The buffer is filled from the array when the count is given, so bytes the host does not write keep their old values.

The array is touched only when a valid confirm arrives with no error pending. The buffer is then copied into the array one bank-width word per clock, and a busy output is held high for the whole copy. A bad confirm byte throws the buffer away. A data write that falls outside the block, or that arrives while the read-only input is high, raises a sticky error flag.

Reads fetch 1, 2 or 4 bytes from the array, in either byte order. After a commit the read port returns the status byte until the host selects array reads again.

Top module: `flash_blkwr`

## Requirements
- R1: After reset, `status` is 0x80, `busy` is low, reads return array data, and every array byte reads 0xFF.
- R2: A read with `rd_en` high returns its data on `rdata` from the next clock edge. `acc_size` 00, 01 and 10 select 1, 2 and 4 bytes, and 11 is taken as 4 bytes. The bytes start at `addr` and go upward. With `big_end` low, the byte at `addr` lands in bits 7:0. With `big_end` high, it lands in the most significant byte that is used. Unused upper bits are zero.
- R3: In idle, a write whose low byte is 0xE8 starts a block program. On the next write, the data masked to the bank width gives a count N, and exactly N+1 data writes follow. The block base is the address of that count write with its low log2(BLK_BYTES) bits cleared.
- R4: When the count write is taken, the shadow buffer is loaded from the array block at the base. Bytes of the block that no data write touches keep their earlier array values after the commit.
- R5: An accepted data write is stored at its offset from the base. It uses the size and byte order of the access, with the same lane rule as reads.
- R6: During the data phase, a write that starts below the base, or whose last byte lies past base+BLK_BYTES-1, sets `status` bit 4 and is not stored. It still counts toward the N+1 writes.
- R7: A data-phase write while `read_only` is high sets `status` bit 4 and is not stored.
- R8: In the confirm state, 0xD0 with bit 4 clear starts the commit. `busy` is high, and `status` bit 7 is low, for exactly BLK_BYTES/BANK_BYTES cycles, starting with the cycle after the confirm. From the confirm onward, reads return `{24'b0, status}` until a 0xFF command.
- R9: In the confirm state, any other byte, or 0xD0 while bit 4 is set, leaves the array unchanged. `busy` stays low and reads return array data.
- R10: While a block program is pending, array reads return the committed contents, not the buffer.
- R11: Writes that arrive while `busy` is high have no effect.
- R12: In idle, 0x50 clears `status` bit 4 and 0xFF selects array reads. Bit 4 holds through all other writes until one of these clears it or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte address |
| acc_size | input | 2 | Access width code |
| big_end | input | 1 | Byte order select, 1 = big-endian |
| read_only | input | 1 | Blocks programming when high |
| wdata | input | 32 | Write data, or command in its low byte |
| rdata | output | 32 | Read data, registered |
| status | output | 8 | Bit 7 ready, bit 4 programming error |
| busy | output | 1 | High while the buffer is being committed |

## Verification
Status and error changes are visible in the cycle right after the write edge that causes them. The bench drives every stimulus on a falling edge and samples on the next falling edge. Read data is registered, so each read is launched on one falling edge and checked on the following one, after exactly one rising edge. The commit is timed by counting falling edges with `busy` high, starting right after the confirm write. That count must equal the number of words in a block, even when a command write lands during the commit.

// File: rtl/flash_blkwr_pkg.sv
package flash_blkwr_pkg;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_COUNT,
      FS_DATA,
      FS_CONFIRM,
      FS_COMMIT
   } fsm_e;

   localparam logic [7:0] OP_BUFWR   = 8'hE8;
   localparam logic [7:0] OP_CONFIRM = 8'hD0;
   localparam logic [7:0] OP_READARR = 8'hFF;
   localparam logic [7:0] OP_CLRSTAT = 8'h50;

   // access size code to a byte count
   function automatic logic [2:0] size_bytes(input logic [1:0] sz);
      case (sz)
         2'b00:   return 3'd1;
         2'b01:   return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

   // byte k of an n-byte access taken from a 32-bit bus word
   function automatic logic [7:0] bus_lane(input logic [31:0] w, input int k,
                                           input int n, input logic big);
      int l;
      l = big ? (n - 1 - k) : k;
      return w[8*l +: 8];
   endfunction

endpackage

// File: rtl/flash_blkwr_array.sv
module flash_blkwr_array
   import flash_blkwr_pkg::*;
#(
   parameter int         ADDR_W     = 8,
   parameter int         BLK_BYTES  = 16,
   parameter int         BANK_BYTES = 4,
   parameter logic [7:0] ERASED     = 8'hFF
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       img_base,
   output logic [BLK_BYTES*8-1:0]  img,
   input  logic                    cw_en,
   input  logic [ADDR_W-1:0]       cw_addr,
   input  logic [BANK_BYTES*8-1:0] cw_data,
   input  logic [ADDR_W-1:0]       rd_addr,
   input  logic [1:0]              rd_size,
   input  logic                    big_end,
   output logic [31:0]             rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0] mem [DEPTH];
   logic [2:0] rd_n;

   // parallel image of one block for the shadow preload
   for (genvar gi = 0; gi < BLK_BYTES; gi++) begin : g_img
      assign img[8*gi +: 8] = mem[img_base + ADDR_W'(gi)];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
      end else if (cw_en) begin
         for (int b = 0; b < BANK_BYTES; b++)
            mem[cw_addr + ADDR_W'(b)] <= cw_data[8*b +: 8];
      end
   end

   assign rd_n = size_bytes(rd_size);

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < 4; k++) begin
         if (k < int'(rd_n)) begin
            if (big_end)
               rd_data[8*(int'(rd_n) - 1 - k) +: 8] = mem[rd_addr + ADDR_W'(k)];
            else
               rd_data[8*k +: 8] = mem[rd_addr + ADDR_W'(k)];
         end
      end
   end

endmodule

// File: rtl/flash_blkwr_stage.sv
module flash_blkwr_stage
   import flash_blkwr_pkg::*;
#(
   parameter int BLK_BYTES = 16,
   localparam int OFF_W    = $clog2(BLK_BYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic [BLK_BYTES*8-1:0] img,
   input  logic                   wr,
   input  logic [OFF_W-1:0]       wr_off,
   input  logic [1:0]             wr_size,
   input  logic                   big_end,
   input  logic [31:0]            wdata,
   output logic [BLK_BYTES*8-1:0] sbuf_flat
);

   logic [7:0] sb [BLK_BYTES];
   logic [2:0] wn;

   assign wn = size_bytes(wr_size);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int j = 0; j < BLK_BYTES; j++) sb[j] <= '0;
      end else if (load) begin
         for (int j = 0; j < BLK_BYTES; j++) sb[j] <= img[8*j +: 8];
      end else if (wr) begin
         for (int k = 0; k < 4; k++)
            if (k < int'(wn))
               sb[int'(wr_off) + k] <= bus_lane(wdata, k, int'(wn), big_end);
      end
   end

   for (genvar gi = 0; gi < BLK_BYTES; gi++) begin : g_flat
      assign sbuf_flat[8*gi +: 8] = sb[gi];
   end

endmodule

// File: rtl/flash_blkwr_ctrl.sv
module flash_blkwr_ctrl
   import flash_blkwr_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int BLK_BYTES  = 16,
   parameter int BANK_BYTES = 4,
   parameter int CNT_W      = 8,
   localparam int WORDS     = BLK_BYTES / BANK_BYTES,
   localparam int IDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1,
   localparam int OFF_W     = $clog2(BLK_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic [1:0]        acc_size,
   input  logic              read_only,
   output logic              busy,
   output logic              err,
   output logic              show_status,
   output logic              load_img,
   output logic [ADDR_W-1:0] img_base,
   output logic              stage_wr,
   output logic [OFF_W-1:0]  stage_off,
   output logic              cw_en,
   output logic [ADDR_W-1:0] cw_addr,
   output logic [IDX_W-1:0]  word_sel
);

   localparam logic [31:0] BANK_MASK = (BANK_BYTES >= 4) ? 32'hFFFF_FFFF
                                       : ((32'd1 << (8*BANK_BYTES)) - 32'd1);
   localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'(BLK_BYTES - 1);

   fsm_e              st;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] base_q;
   logic              err_q;
   logic              show_q;
   logic [IDX_W-1:0]  idx;

   logic [7:0]        cmd;
   logic [2:0]        nb;
   logic [ADDR_W:0]   lo_e, hi_e, base_e, top_e;
   logic              oow;
   logic [31:0]       cnt_masked;

   assign cmd        = wdata[7:0];
   assign nb         = size_bytes(acc_size);
   assign cnt_masked = wdata & BANK_MASK;

   // window test carries one extra address bit so base+block never wraps
   assign lo_e   = {1'b0, addr};
   assign hi_e   = lo_e + (ADDR_W+1)'(nb);
   assign base_e = {1'b0, base_q};
   assign top_e  = base_e + (ADDR_W+1)'(BLK_BYTES);
   assign oow    = (lo_e < base_e) || (hi_e > top_e);

   assign img_base  = addr & BLK_MASK;
   assign load_img  = wr_en && (st == FS_COUNT);
   assign stage_wr  = wr_en && (st == FS_DATA) && !read_only && !oow;
   assign stage_off = OFF_W'(addr - base_q);
   assign busy      = (st == FS_COMMIT);
   assign cw_en     = (st == FS_COMMIT);
   assign cw_addr   = base_q | ADDR_W'(int'(idx) * BANK_BYTES);
   assign word_sel  = idx;
   assign err       = err_q;
   assign show_status = show_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= FS_IDLE;
         cnt    <= '0;
         base_q <= '0;
         err_q  <= 1'b0;
         show_q <= 1'b0;
         idx    <= '0;
      end else begin
         case (st)
            FS_IDLE: begin
               if (wr_en) begin
                  case (cmd)
                     OP_BUFWR:   st     <= FS_COUNT;
                     OP_READARR: show_q <= 1'b0;
                     OP_CLRSTAT: err_q  <= 1'b0;
                     default:    ;
                  endcase
               end
            end
            FS_COUNT: begin
               if (wr_en) begin
                  cnt    <= cnt_masked[CNT_W-1:0];
                  base_q <= img_base;
                  st     <= FS_DATA;
               end
            end
            FS_DATA: begin
               if (wr_en) begin
                  if (read_only || oow) err_q <= 1'b1;
                  if (cnt == '0) st <= FS_CONFIRM;
                  cnt <= cnt - 1'b1;
               end
            end
            FS_CONFIRM: begin
               if (wr_en) begin
                  if (cmd == OP_CONFIRM && !err_q) begin
                     st     <= FS_COMMIT;
                     idx    <= '0;
                     show_q <= 1'b1;
                  end else begin
                     st     <= FS_IDLE;
                     show_q <= 1'b0;
                  end
               end
            end
            FS_COMMIT: begin
               idx <= idx + 1'b1;
               if (idx == IDX_W'(WORDS - 1)) st <= FS_IDLE;
            end
            default: st <= FS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/flash_blkwr.sv
module flash_blkwr
   import flash_blkwr_pkg::*;
#(
   parameter int         ADDR_W     = 8,
   parameter int         BLK_BYTES  = 16,
   parameter int         BANK_BYTES = 4,
   parameter int         CNT_W      = 8,
   parameter logic [7:0] ERASED     = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        acc_size,
   input  logic              big_end,
   input  logic              read_only,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic [7:0]        status,
   output logic              busy
);

   localparam int WORDS  = BLK_BYTES / BANK_BYTES;
   localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int OFF_W  = $clog2(BLK_BYTES);
   localparam int BANK_W = BANK_BYTES * 8;

   // configuration checks
   if (BANK_BYTES != 1 && BANK_BYTES != 2 && BANK_BYTES != 4) begin : g_bad_bank
      $error("bank width must be 1, 2 or 4 bytes");
   end
   if ((BLK_BYTES & (BLK_BYTES - 1)) != 0 || BLK_BYTES < BANK_BYTES) begin : g_bad_blk
      $error("block size must be a power of two no smaller than the bank");
   end
   if (BLK_BYTES > (1 << ADDR_W)) begin : g_bad_depth
      $error("block larger than the array");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("count width out of range");
   end

   logic                   err;
   logic                   show_status;
   logic                   load_img;
   logic [ADDR_W-1:0]      img_base;
   logic [BLK_BYTES*8-1:0] img;
   logic                   stage_wr;
   logic [OFF_W-1:0]       stage_off;
   logic [BLK_BYTES*8-1:0] sbuf_flat;
   logic                   cw_en;
   logic [ADDR_W-1:0]      cw_addr;
   logic [IDX_W-1:0]       word_sel;
   logic [BANK_W-1:0]      cw_data;
   logic [31:0]            arr_rd;

   flash_blkwr_ctrl #(
      .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES),
      .BANK_BYTES(BANK_BYTES), .CNT_W(CNT_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .acc_size(acc_size), .read_only(read_only), .busy(busy), .err(err),
      .show_status(show_status), .load_img(load_img), .img_base(img_base),
      .stage_wr(stage_wr), .stage_off(stage_off), .cw_en(cw_en),
      .cw_addr(cw_addr), .word_sel(word_sel)
   );

   flash_blkwr_stage #(.BLK_BYTES(BLK_BYTES)) u_stage (
      .clk(clk), .rst_n(rst_n), .load(load_img), .img(img), .wr(stage_wr),
      .wr_off(stage_off), .wr_size(acc_size), .big_end(big_end),
      .wdata(wdata), .sbuf_flat(sbuf_flat)
   );

   assign cw_data = sbuf_flat[int'(word_sel)*BANK_W +: BANK_W];

   flash_blkwr_array #(
      .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES),
      .BANK_BYTES(BANK_BYTES), .ERASED(ERASED)
   ) u_array (
      .clk(clk), .rst_n(rst_n), .img_base(img_base), .img(img),
      .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
      .rd_addr(addr), .rd_size(acc_size), .big_end(big_end), .rd_data(arr_rd)
   );

   assign status = {~busy, 2'b00, err, 4'b0000};

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= show_status ? {24'b0, status} : arr_rd;
   end

endmodule

// File: rtl/flash_blkwr_chk.sv
module flash_blkwr_chk #(
   parameter int BLK_BYTES  = 16,
   parameter int BANK_BYTES = 4
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [31:0] wdata,
   input logic [7:0]  status,
   input logic        busy
);

   localparam int WORDS = BLK_BYTES / BANK_BYTES;

   logic [15:0] run;

   always_ff @(posedge clk) begin
      if (!rst_n)    run <= '0;
      else if (busy) run <= run + 16'd1;
      else           run <= '0;
   end

   AST_COMMIT_NEEDS_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(wr_en) && $past(wdata[7:0]) == 8'hD0 && !$past(status[4]))); // R8

   AST_ERR_BLOCKS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && status[4] && !busy) |=> !busy); // R9

   AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (status[4] && !(wr_en && wdata[7:0] == 8'h50)) |=> status[4]); // R12

   AST_COMMIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run < 16'(WORDS))); // R8

   AST_COMMIT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run == 16'(WORDS))); // R8

endmodule

bind flash_blkwr flash_blkwr_chk #(.BLK_BYTES(BLK_BYTES), .BANK_BYTES(BANK_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
   .status(status), .busy(busy)
);

// File: tb/flash_blkwr_test.sv
`timescale 1ns/1ps
module flash_blkwr_test;

   localparam int AW    = 8;
   localparam int BLK   = 16;
   localparam int BANK  = 4;
   localparam int WORDS = BLK / BANK;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [1:0]    acc_size = '0;
   logic          big_end = 1'b0, read_only = 1'b0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [7:0]    status;
   logic          busy;

   int checks = 0, errors = 0;
   bit finished = 0;
   logic [7:0] model [DEPTH];
   logic [7:0] stg [BLK];
   int stg_base;

   flash_blkwr #(.ADDR_W(AW), .BLK_BYTES(BLK), .BANK_BYTES(BANK)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .acc_size(acc_size), .big_end(big_end), .read_only(read_only),
      .wdata(wdata), .rdata(rdata), .status(status), .busy(busy)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int nbytes(input int sz);
      return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
   endfunction

   function automatic logic [31:0] exp_rd(input int a, input int sz, input bit be);
      logic [31:0] r;
      int n;
      n = nbytes(sz);
      r = '0;
      for (int k = 0; k < n; k++) begin
         if (be) r[8*(n-1-k) +: 8] = model[(a + k) % DEPTH];
         else    r[8*k +: 8]       = model[(a + k) % DEPTH];
      end
      return r;
   endfunction

   task automatic wr(input int a, input logic [31:0] d, input int sz, input bit be);
      addr = AW'(a); wdata = d; acc_size = 2'(sz); big_end = be; wr_en = 1'b1;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, input int sz, input bit be, output logic [31:0] q);
      addr = AW'(a); acc_size = 2'(sz); big_end = be; rd_en = 1'b1;
      @(posedge clk); @(negedge clk);
      rd_en = 1'b0;
      q = rdata;
   endtask

   task automatic chk_rd(input int a, input int sz, input bit be, input string tag);
      logic [31:0] q;
      rd(a, sz, be, q);
      chk(q == exp_rd(a, sz, be), tag, q, exp_rd(a, sz, be));
   endtask

   task automatic stage_open(input int a);
      stg_base = a & ~(BLK - 1);
      for (int j = 0; j < BLK; j++) stg[j] = model[stg_base + j];
   endtask

   task automatic stage_put(input int a, input logic [31:0] d, input int sz, input bit be);
      int n;
      n = nbytes(sz);
      for (int k = 0; k < n; k++)
         stg[a - stg_base + k] = be ? d[8*(n-1-k) +: 8] : d[8*k +: 8];
   endtask

   task automatic stage_commit();
      for (int j = 0; j < BLK; j++) model[stg_base + j] = stg[j];
   endtask

   task automatic count_busy(output int n);
      n = 0;
      while (busy && n < 100) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] q, d;
      int n, nw, base, sz;
      bit be;
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(status == 8'h80, "R1 status", {24'b0, status}, 32'h80);
      chk(busy == 1'b0, "R1 busy", {31'b0, busy}, 32'h0);
      chk_rd(8'h00, 2, 0, "R1 erased");
      chk_rd(8'hFC, 2, 1, "R1 erased top");

      // R3 R5 R8 sweep: every block, rotating size and byte order
      for (int b = 0; b < DEPTH / BLK; b++) begin
         be = b[0]; sz = b % 3; n = nbytes(sz); nw = BLK / n; base = b * BLK;
         wr(base, 32'hE8, 0, be);
         wr(base + 7, 32'(nw - 1), 2, be);
         stage_open(base + 7);
         for (int i = 0; i < nw; i++) begin
            d = 32'((b * 32 + i + 1) * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
            wr(base + i * n, d, sz, be);
            stage_put(base + i * n, d, sz, be);
         end
         wr(base, 32'hD0, 0, 0);
         chk(busy == 1'b1 && status == 8'h00, "R8 busy at commit start", {23'b0, busy, status}, 32'h100);
         count_busy(n);
         chk(n == WORDS, "R8 commit cycles", 32'(n), 32'(WORDS));
         stage_commit();
         rd(base, 2, 0, q);
         chk(q == 32'h80, "R8 status read after commit", q, 32'h80);
         wr(0, 32'hFF, 0, 0);
      end

      // R2 R5 readback over whole array, all sizes and orders
      for (int a = 0; a < DEPTH; a++)
         for (int s = 0; s < 3; s++)
            for (int e = 0; e < 2; e++)
               chk_rd(a, s, e[0], "R2 R5 readback");
      chk_rd(8'h13, 3, 0, "R2 size code 3");

      // R4 R10 partial write keeps preloaded bytes
      wr(8'h20, 32'hE8, 0, 0);
      wr(8'h23, 32'h0, 2, 0);
      stage_open(8'h23);
      wr(8'h25, 32'h0000_ABCD, 1, 1);
      stage_put(8'h25, 32'h0000_ABCD, 1, 1);
      chk_rd(8'h24, 2, 0, "R10 pending read");
      wr(8'h20, 32'hD0, 0, 0);
      count_busy(n);
      stage_commit();
      wr(0, 32'hFF, 0, 0);
      for (int a = 8'h20; a < 8'h30; a++) chk_rd(a, 0, 0, "R4 preload kept");

      // R6 below the window, then D0 refused (R9)
      wr(8'h40, 32'hE8, 0, 0);
      wr(8'h44, 32'h1, 2, 0);
      wr(8'h3E, 32'h1122_3344, 2, 0);
      chk(status == 8'h90, "R6 below base", {24'b0, status}, 32'h90);
      wr(8'h48, 32'h55, 0, 0);
      wr(8'h40, 32'hD0, 0, 0);
      chk(busy == 1'b0, "R9 D0 with error", {31'b0, busy}, 32'h0);
      chk_rd(8'h3C, 2, 0, "R6 nothing stored below");
      chk_rd(8'h48, 2, 0, "R9 array unchanged");
      wr(0, 32'hFF, 0, 0);
      chk(status == 8'h90, "R12 error sticky", {24'b0, status}, 32'h90);
      wr(0, 32'h50, 0, 0);
      chk(status == 8'h80, "R12 clear", {24'b0, status}, 32'h80);

      // R6 straddling the top of the window
      wr(8'h40, 32'hE8, 0, 0);
      wr(8'h40, 32'h0, 2, 0);
      wr(8'h4F, 32'h7777, 1, 0);
      chk(status == 8'h90, "R6 past end", {24'b0, status}, 32'h90);
      wr(8'h40, 32'hD0, 0, 0);
      chk(busy == 1'b0, "R6 no commit", {31'b0, busy}, 32'h0);
      chk_rd(8'h4E, 1, 0, "R6 unchanged");
      chk_rd(8'h50, 1, 0, "R6 next block unchanged");
      wr(0, 32'h50, 0, 0);

      // R9 abort by another byte
      wr(8'h50, 32'hE8, 0, 0);
      wr(8'h50, 32'h0, 2, 0);
      wr(8'h54, 32'hDEAD_BEEF, 2, 0);
      chk(status == 8'h80, "R9 clean data", {24'b0, status}, 32'h80);
      wr(8'h50, 32'h77, 0, 0);
      chk(busy == 1'b0, "R9 abort no busy", {31'b0, busy}, 32'h0);
      chk_rd(8'h54, 2, 0, "R9 abort array unchanged");

      // R7 read-only
      read_only = 1'b1;
      wr(8'h60, 32'hE8, 0, 0);
      wr(8'h60, 32'h0, 2, 0);
      wr(8'h60, 32'h1234, 1, 0);
      chk(status == 8'h90, "R7 read-only error", {24'b0, status}, 32'h90);
      wr(8'h60, 32'hD0, 0, 0);
      chk(busy == 1'b0, "R7 no commit", {31'b0, busy}, 32'h0);
      chk_rd(8'h60, 1, 0, "R7 array unchanged");
      read_only = 1'b0;
      wr(0, 32'h50, 0, 0);

      // R11 writes during commit ignored
      wr(8'h70, 32'hE8, 0, 0);
      wr(8'h70, 32'(WORDS - 1), 2, 0);
      stage_open(8'h70);
      for (int i = 0; i < WORDS; i++) begin
         d = 32'hC0DE_0000 + 32'(i * 16'h1111);
         wr(8'h70 + i * 4, d, 2, 0);
         stage_put(8'h70 + i * 4, d, 2, 0);
      end
      wr(8'h70, 32'hD0, 0, 0);
      wr(8'h70, 32'hFF, 0, 0);
      count_busy(n);
      chk(n + 1 == WORDS, "R11 commit length kept", 32'(n + 1), 32'(WORDS));
      rd(8'h70, 2, 0, q);
      chk(q == 32'h80, "R11 read-array command ignored", q, 32'h80);
      stage_commit();
      wr(0, 32'hFF, 0, 0);
      for (int i = 0; i < WORDS; i++) chk_rd(8'h70 + i * 4, 2, 0, "R11 R5 committed data");

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule